// File: doc/BRIEF.md
# Banked Serial Configuration Port

This block is the configuration path of an analog line front end. A host controller drives a serial clock, a frame sync pulse and a data line. It receives the read data on a separate output line that has its own output enable. Each frame is a 16-bit command. The command holds a direction bit, a 3-bit bank select and a 12-bit payload. The payload either replaces the contents of one of the addressed register banks or is ignored while that bank streams back to the host inside the same frame.

The serial lines are asynchronous to the block clock. They pass through a synchronizer and are sampled on each detected falling edge of the serial clock. Three banks hold state: a control word, a transmit filter corner word and a receive filter corner word. A fourth select value names a reserved test bank. The control word is decoded into channel enables, a loopback enable, four path bypass controls, a transmit attenuation select, a direct DAC output select and a receive PGA gain. A broadcast flag in either filter bank writes the same corner word to both filters in one frame.

Top module: `scp_port`

## Requirements
- R1: A frame starts at the falling edge of `ser_clk` at which `ser_fs` is sampled high after being sampled low at the previous falling edge. That edge carries the first bit. The 16 bits arrive most significant first: bit 15 is the direction (1 = read), bits 14:12 are the bank select, and bits 11:0 are the payload.
- R2: A write (bit 15 = 0) changes a bank only after the 16th bit of its frame. A frame cut short by a new frame start commits nothing, and outside a write commit the decoded outputs hold their values.
- R3: On a read, `ser_dout_oe` rises after the 4th falling edge of the frame. The addressed bank is then presented bit 11 first, one bit per edge, so the host samples bit 11 at the 5th falling edge and bit 0 at the 16th. `ser_dout_oe` drops after the 16th edge. On write frames `ser_dout_oe` stays low, and `ser_dout` is 0 whenever `ser_dout_oe` is low.
- R4: Bank 0 (select 000) is the control word. Bit 11 = transmit channel on and bit 10 = receive channel on; a 0 in either bit powers that channel down. Bit 9 = loopback, bit 8 = ADC buffer bypass, bit 7 = receive filter bypass, bit 6 = transmit 6 dB attenuation, bit 5 = DAC output routed directly, bit 4 = transmit filter bypass, bit 3 = line driver bypass, and bits 2:0 = PGA code.
- R5: The PGA code gives the gain in dB as follows: 000 gives -6, 001 gives -3, 010 gives 0, 011 gives 3, 100 gives 6, and 101, 110 and 111 all give 9.
- R6: Bank 1 (select 001) holds the transmit filter word and bank 2 (select 010) the receive filter word, each taken from payload bits 10:0. Reading either bank returns its word with bit 11 as 0.
- R7: A write to bank 1 or bank 2 with payload bit 11 set loads payload bits 10:0 into both filter words.
- R8: Writes to select 011 and to selects 100 through 111 change nothing, and reads of these selects return zero.
- R9: While `rst_n` is low, all banks clear to zero. Both channels are then powered down, every other control output is 0, the PGA gain is -6 dB and `ser_dout_oe` is low.
- R10: A read frame leaves every bank and every decoded output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_fs | input | 1 | Frame start pulse |
| ser_din | input | 1 | Serial command data |
| ser_dout | output | 1 | Serial read data |
| ser_dout_oe | output | 1 | High while `ser_dout` carries read data |
| tx_chan_on | output | 1 | Transmit channel powered |
| rx_chan_on | output | 1 | Receive channel powered |
| loopback_en | output | 1 | Analog loopback selected |
| adc_buf_bypass | output | 1 | ADC buffer bypassed |
| rx_filt_bypass | output | 1 | Receive filter bypassed |
| tx_atten_6db | output | 1 | Transmit filter output attenuated by 6 dB |
| tx_dac_direct | output | 1 | DAC output routed directly |
| tx_filt_bypass | output | 1 | Transmit filter bypassed |
| tx_drv_bypass | output | 1 | Line driver bypassed |
| pga_code | output | 3 | Raw receive PGA code |
| pga_gain_db | output | 5 | Receive PGA gain in dB, signed |
| tx_filt_word | output | 11 | Transmit filter corner word |
| rx_filt_word | output | 11 | Receive filter corner word |

## Verification
The bench builds the port with its default two-stage synchronizer. It runs the serial clock at sixteen block clocks per bit. At that ratio the synchronizer latency and the registered edge detector settle well inside one half bit. This lets the bench sample read data exactly at the host's falling edge and catch an off-by-one in the in-frame readout. Bank select, payload and direction are randomized over the full 16-bit space, so every select value, including the reserved and unmapped ones, is reached alongside directed broadcast, truncated-frame and mid-run reset cases.

// File: rtl/scp_pkg.sv
`timescale 1ns/1ps
package scp_pkg;

    localparam int SEL_W  = 3;
    localparam int DATA_W = 12;
    localparam int HDR_W  = 1 + SEL_W;
    localparam int CMD_W  = HDR_W + DATA_W;
    localparam int FILT_W = DATA_W - 1;
    localparam int CNT_W  = $clog2(CMD_W + 1);
    localparam int PGA_W  = 3;
    localparam int GAIN_W = 5;

    localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_TXF  = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_RXF  = SEL_W'(2);

    // Field order matches control word bit positions, high to low.
    typedef struct packed {
        logic             tx_on;
        logic             rx_on;
        logic             loopback;
        logic             adc_buf_bp;
        logic             rx_filt_bp;
        logic             tx_atten;
        logic             tx_dac_direct;
        logic             tx_filt_bp;
        logic             tx_drv_bp;
        logic [PGA_W-1:0] pga;
    } ctrl_fields_t;

    function automatic logic signed [GAIN_W-1:0] pga_db(input logic [PGA_W-1:0] code);
        logic signed [GAIN_W-1:0] g;
        case (code)
            3'd0:    g = -5'sd6;
            3'd1:    g = -5'sd3;
            3'd2:    g = 5'sd0;
            3'd3:    g = 5'sd3;
            3'd4:    g = 5'sd6;
            default: g = 5'sd9;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/scp_sync.sv
`timescale 1ns/1ps
module scp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign chain_d[s] = async_in;
        end else begin : g_next
            assign chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/scp_deser.sv
`timescale 1ns/1ps
module scp_deser
    import scp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             fs,
    input  logic             din,
    output logic             start_stb,
    output logic             bit_stb,
    output logic             hdr_stb,
    output logic             done_stb,
    output logic             hdr_rw,
    output logic [SEL_W-1:0] hdr_sel,
    output logic [CMD_W-1:0] cmd_word
);

    typedef struct packed {
        logic             sclk_prev;
        logic             fs_prev;
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [CMD_W-1:0] sh;
        logic             start_stb;
        logic             bit_stb;
        logic             hdr_stb;
        logic             done_stb;
    } deser_t;

    deser_t st_d, st_q;
    logic   fall;

    always_comb begin
        st_d           = st_q;
        st_d.start_stb = 1'b0;
        st_d.bit_stb   = 1'b0;
        st_d.hdr_stb   = 1'b0;
        st_d.done_stb  = 1'b0;
        st_d.sclk_prev = sclk;
        fall           = st_q.sclk_prev & ~sclk;

        if (fall) begin
            st_d.fs_prev = fs;
            if (fs && !st_q.fs_prev) begin
                // new frame: this edge carries the first bit
                st_d.sh        = {{(CMD_W-1){1'b0}}, din};
                st_d.cnt       = CNT_W'(1);
                st_d.active    = 1'b1;
                st_d.start_stb = 1'b1;
                st_d.bit_stb   = 1'b1;
            end else if (st_q.active) begin
                st_d.sh      = {st_q.sh[CMD_W-2:0], din};
                st_d.cnt     = st_q.cnt + CNT_W'(1);
                st_d.bit_stb = 1'b1;
                if (st_d.cnt == CNT_W'(CMD_W)) begin
                    st_d.active   = 1'b0;
                    st_d.done_stb = 1'b1;
                end
            end
            if (st_d.bit_stb && st_d.cnt == CNT_W'(HDR_W)) begin
                st_d.hdr_stb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_stb = st_q.start_stb;
    assign bit_stb   = st_q.bit_stb;
    assign hdr_stb   = st_q.hdr_stb;
    assign done_stb  = st_q.done_stb;
    assign hdr_rw    = st_q.sh[HDR_W-1];
    assign hdr_sel   = st_q.sh[SEL_W-1:0];
    assign cmd_word  = st_q.sh;

endmodule

// File: rtl/scp_banks.sv
`timescale 1ns/1ps
module scp_banks
    import scp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [SEL_W-1:0]         rd_sel,
    output logic [DATA_W-1:0]        rd_data,
    output ctrl_fields_t             ctrl,
    output logic signed [GAIN_W-1:0] gain_db,
    output logic [FILT_W-1:0]        txf_word,
    output logic [FILT_W-1:0]        rxf_word
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [FILT_W-1:0] txf;
        logic [FILT_W-1:0] rxf;
    } bank_t;

    bank_t bk_d, bk_q;
    logic  both;

    always_comb begin
        bk_d = bk_q;
        both = wr_data[DATA_W-1];
        if (wr_stb) begin
            case (wr_sel)
                SEL_CTRL: bk_d.ctrl = wr_data;
                SEL_TXF: begin
                    bk_d.txf = wr_data[FILT_W-1:0];
                    if (both) bk_d.rxf = wr_data[FILT_W-1:0];
                end
                SEL_RXF: begin
                    bk_d.rxf = wr_data[FILT_W-1:0];
                    if (both) bk_d.txf = wr_data[FILT_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    always_comb begin
        case (rd_sel)
            SEL_CTRL: rd_data = bk_q.ctrl;
            SEL_TXF:  rd_data = {1'b0, bk_q.txf};
            SEL_RXF:  rd_data = {1'b0, bk_q.rxf};
            default:  rd_data = '0;
        endcase
    end

    assign ctrl     = ctrl_fields_t'(bk_q.ctrl);
    assign gain_db  = pga_db(ctrl.pga);
    assign txf_word = bk_q.txf;
    assign rxf_word = bk_q.rxf;

endmodule

// File: rtl/scp_txshift.sv
`timescale 1ns/1ps
module scp_txshift
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_stb,
    input  logic              bit_stb,
    input  logic              hdr_stb,
    input  logic              hdr_rw,
    input  logic              done_stb,
    input  logic [DATA_W-1:0] load_data,
    output logic              dout,
    output logic              dout_oe
);

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] sh;
    } shf_t;

    shf_t sf_d, sf_q;

    always_comb begin
        sf_d = sf_q;
        if (hdr_stb && hdr_rw) begin
            sf_d.en = 1'b1;
            sf_d.sh = load_data;
        end else if (start_stb || done_stb) begin
            sf_d.en = 1'b0;
            sf_d.sh = '0;
        end else if (bit_stb && sf_q.en) begin
            sf_d.sh = {sf_q.sh[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sf_q <= '0;
        else        sf_q <= sf_d;
    end

    assign dout    = sf_q.en & sf_q.sh[DATA_W-1];
    assign dout_oe = sf_q.en;

endmodule

// File: rtl/scp_port.sv
`timescale 1ns/1ps
module scp_port
    import scp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_fs,
    input  logic                     ser_din,
    output logic                     ser_dout,
    output logic                     ser_dout_oe,
    output logic                     tx_chan_on,
    output logic                     rx_chan_on,
    output logic                     loopback_en,
    output logic                     adc_buf_bypass,
    output logic                     rx_filt_bypass,
    output logic                     tx_atten_6db,
    output logic                     tx_dac_direct,
    output logic                     tx_filt_bypass,
    output logic                     tx_drv_bypass,
    output logic [2:0]               pga_code,
    output logic signed [4:0]        pga_gain_db,
    output logic [10:0]              tx_filt_word,
    output logic [10:0]              rx_filt_word
);

    logic [2:0]        synced;
    logic              start_stb, bit_stb, hdr_stb, done_stb, hdr_rw;
    logic [SEL_W-1:0]  hdr_sel;
    logic [CMD_W-1:0]  cmd_word;
    logic [DATA_W-1:0] rd_data;
    logic              wr_stb;
    ctrl_fields_t      ctrl;

    scp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_clk, ser_fs, ser_din}),
        .sync_out (synced)
    );

    scp_deser u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (synced[2]),
        .fs        (synced[1]),
        .din       (synced[0]),
        .start_stb (start_stb),
        .bit_stb   (bit_stb),
        .hdr_stb   (hdr_stb),
        .done_stb  (done_stb),
        .hdr_rw    (hdr_rw),
        .hdr_sel   (hdr_sel),
        .cmd_word  (cmd_word)
    );

    assign wr_stb = done_stb & ~cmd_word[CMD_W-1];

    scp_banks u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_sel   (cmd_word[CMD_W-2 -: SEL_W]),
        .wr_data  (cmd_word[DATA_W-1:0]),
        .rd_sel   (hdr_sel),
        .rd_data  (rd_data),
        .ctrl     (ctrl),
        .gain_db  (pga_gain_db),
        .txf_word (tx_filt_word),
        .rxf_word (rx_filt_word)
    );

    scp_txshift u_txshift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_stb (start_stb),
        .bit_stb   (bit_stb),
        .hdr_stb   (hdr_stb),
        .hdr_rw    (hdr_rw),
        .done_stb  (done_stb),
        .load_data (rd_data),
        .dout      (ser_dout),
        .dout_oe   (ser_dout_oe)
    );

    assign tx_chan_on     = ctrl.tx_on;
    assign rx_chan_on     = ctrl.rx_on;
    assign loopback_en    = ctrl.loopback;
    assign adc_buf_bypass = ctrl.adc_buf_bp;
    assign rx_filt_bypass = ctrl.rx_filt_bp;
    assign tx_atten_6db   = ctrl.tx_atten;
    assign tx_dac_direct  = ctrl.tx_dac_direct;
    assign tx_filt_bypass = ctrl.tx_filt_bp;
    assign tx_drv_bypass  = ctrl.tx_drv_bp;
    assign pga_code       = ctrl.pga;

endmodule

// File: rtl/scp_port_chk.sv
`timescale 1ns/1ps
module scp_port_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_dout,
    input logic              ser_dout_oe,
    input logic              hdr_stb,
    input logic              done_stb,
    input logic              start_stb,
    input logic [2:0]        pga_code,
    input logic signed [4:0] pga_gain_db,
    input logic [10:0]       tx_filt_word,
    input logic [10:0]       rx_filt_word
);

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_dout_oe |-> !ser_dout); // R3

    AST_OE_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_dout_oe) |-> $past(hdr_stb)); // R3

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_dout_oe) |-> $past(done_stb || start_stb)); // R3

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done_stb) |-> ($stable(tx_filt_word) && $stable(rx_filt_word) && $stable(pga_code))); // R2

    AST_PGA_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pga_code[2:1] == 2'b11) |-> (pga_gain_db == 5'sd9)); // R5

endmodule

bind scp_port scp_port_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_dout     (ser_dout),
    .ser_dout_oe  (ser_dout_oe),
    .hdr_stb      (hdr_stb),
    .done_stb     (done_stb),
    .start_stb    (start_stb),
    .pga_code     (pga_code),
    .pga_gain_db  (pga_gain_db),
    .tx_filt_word (tx_filt_word),
    .rx_filt_word (rx_filt_word)
);

// File: tb/scp_port_tb.sv
`timescale 1ns/1ps
module scp_port_tb;

    localparam int CLK_HALF = 4;
    localparam int BIT_HALF = 64;
    localparam int WD_NS    = 1_400_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b1;
    logic ser_fs = 1'b0;
    logic ser_din = 1'b0;
    logic ser_dout, ser_dout_oe;
    logic tx_chan_on, rx_chan_on, loopback_en, adc_buf_bypass, rx_filt_bypass;
    logic tx_atten_6db, tx_dac_direct, tx_filt_bypass, tx_drv_bypass;
    logic [2:0] pga_code;
    logic signed [4:0] pga_gain_db;
    logic [10:0] tx_filt_word, rx_filt_word;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [11:0] m_ctrl = '0;
    logic [10:0] m_txf = '0;
    logic [10:0] m_rxf = '0;

    always #(CLK_HALF) clk = ~clk;

    scp_port u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_fs(ser_fs), .ser_din(ser_din),
        .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
        .tx_chan_on(tx_chan_on), .rx_chan_on(rx_chan_on), .loopback_en(loopback_en),
        .adc_buf_bypass(adc_buf_bypass), .rx_filt_bypass(rx_filt_bypass),
        .tx_atten_6db(tx_atten_6db), .tx_dac_direct(tx_dac_direct),
        .tx_filt_bypass(tx_filt_bypass), .tx_drv_bypass(tx_drv_bypass),
        .pga_code(pga_code), .pga_gain_db(pga_gain_db),
        .tx_filt_word(tx_filt_word), .rx_filt_word(rx_filt_word)
    );

    function automatic int exp_gain(input logic [2:0] c);
        case (c)
            3'd0: return -6;
            3'd1: return -3;
            3'd2: return 0;
            3'd3: return 3;
            3'd4: return 6;
            default: return 9;
        endcase
    endfunction

    function automatic logic [11:0] exp_rd(input logic [2:0] sel);
        case (sel)
            3'd0: return m_ctrl;
            3'd1: return {1'b0, m_txf};
            3'd2: return {1'b0, m_rxf};
            default: return 12'd0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_write(input logic [15:0] w);
        if (!w[15]) begin
            case (w[14:12])
                3'd0: m_ctrl = w[11:0];
                3'd1: begin m_txf = w[10:0]; if (w[11]) m_rxf = w[10:0]; end
                3'd2: begin m_rxf = w[10:0]; if (w[11]) m_txf = w[10:0]; end
                default: ;
            endcase
        end
    endtask

    // shifts nbits of w onto the line; samples read data at each falling edge
    task automatic run_frame(input logic [15:0] w, input int nbits,
                             output logic [11:0] rd, output bit oe_ok);
        rd = '0;
        oe_ok = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            ser_din = w[15-i];
            ser_fs = (i == 0);
            #(BIT_HALF);
            if (i >= 4) begin
                if (ser_dout_oe !== w[15]) oe_ok = 1'b0;
                rd = {rd[10:0], ser_dout};
            end else if (ser_dout_oe !== 1'b0) begin
                oe_ok = 1'b0;
            end
            ser_clk = 1'b0;
            #(BIT_HALF);
            ser_clk = 1'b1;
        end
        ser_fs = 1'b0;
        ser_din = 1'b0;
        #(BIT_HALF * 2);
    endtask

    task automatic check_outputs(input string req);
        logic [11:0] got;
        got = {tx_chan_on, rx_chan_on, loopback_en, adc_buf_bypass, rx_filt_bypass,
               tx_atten_6db, tx_dac_direct, tx_filt_bypass, tx_drv_bypass, pga_code};
        check(got === m_ctrl, {req, "/R4"}, "control outputs", int'(got), int'(m_ctrl));
        check(int'(pga_gain_db) == exp_gain(m_ctrl[2:0]), {req, "/R5"}, "pga gain",
              int'(pga_gain_db), exp_gain(m_ctrl[2:0]));
        check(tx_filt_word === m_txf, {req, "/R6"}, "tx filter word",
              int'(tx_filt_word), int'(m_txf));
        check(rx_filt_word === m_rxf, {req, "/R6"}, "rx filter word",
              int'(rx_filt_word), int'(m_rxf));
        check(ser_dout_oe === 1'b0, {req, "/R3"}, "oe idle", int'(ser_dout_oe), 0);
    endtask

    task automatic do_frame(input logic [15:0] w, input string req);
        logic [11:0] rd;
        logic [11:0] exp;
        bit oe_ok;
        exp = exp_rd(w[14:12]);
        run_frame(w, 16, rd, oe_ok);
        check(oe_ok, {req, "/R3"}, "output enable window", int'(oe_ok), 1);
        if (w[15]) begin
            check(rd === exp, (w[14:12] >= 3'd3) ? {req, "/R8"} : {req, "/R3"},
                  "read data", int'(rd), int'(exp));
        end
        model_write(w);
        check_outputs(req);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        #(WD_NS);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin : main
        logic [11:0] rd;
        bit oe_ok;
        int seed;
        logic [15:0] w;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9: reset state
        check(pga_gain_db == -5'sd6, "R9", "reset gain", int'(pga_gain_db), -6);
        check(tx_chan_on === 1'b0 && rx_chan_on === 1'b0, "R9", "channels powered down",
              int'({tx_chan_on, rx_chan_on}), 0);
        check_outputs("R9");
        do_frame(16'h8000, "R9 read ctrl after reset");

        // R1 R4: control word decode
        do_frame(16'h0A5C, "R1 ctrl write");
        do_frame(16'h8000, "R1 ctrl read");
        do_frame(16'h0C00, "R4 channels on");
        do_frame(16'h03F8, "R4 bypass bits");

        // R5: every PGA code
        for (int c = 0; c < 8; c++) do_frame({4'h0, 9'h100, c[2:0]}, "R5 pga code");

        // R6: separate filter words and readback with bit 11 clear
        do_frame(16'h1123, "R6 tx word");
        do_frame(16'h2456, "R6 rx word");
        do_frame(16'h9000, "R6 tx read");
        do_frame(16'hA000, "R6 rx read");

        // R7: broadcast from either filter bank
        do_frame(16'h1F0F, "R7 both via tx");
        check(tx_filt_word === 11'h70F && rx_filt_word === 11'h70F, "R7", "both from tx",
              int'(rx_filt_word), 'h70F);
        do_frame(16'h2ABC, "R7 both via rx");
        check(tx_filt_word === 11'h2BC && rx_filt_word === 11'h2BC, "R7", "both from rx",
              int'(tx_filt_word), 'h2BC);
        do_frame(16'h9000, "R7 tx read flag clear");

        // R8: reserved and unmapped selects
        do_frame(16'h3FFF, "R8 reserved write");
        do_frame(16'h5FFF, "R8 unmapped write");
        do_frame(16'h7FFF, "R8 unmapped write top");
        do_frame(16'hB000, "R8 reserved read");
        do_frame(16'hE000, "R8 unmapped read");

        // R10: reads do not disturb state
        do_frame(16'h8FFF, "R10 read ctrl");
        do_frame(16'h9FFF, "R10 read tx");
        do_frame(16'hAFFF, "R10 read rx");

        // R2: a truncated write commits nothing
        run_frame(16'h1555, 10, rd, oe_ok);
        check(tx_filt_word === m_txf, "R2", "truncated write no commit",
              int'(tx_filt_word), int'(m_txf));
        run_frame(16'h0FFF, 15, rd, oe_ok);
        check_outputs("R2 after 15 bits");
        do_frame(16'h1321, "R2 full write after abort");

        // random mix
        seed = $urandom(32'h5C0F_1E42);
        for (int k = 0; k < 250; k++) begin
            w = 16'($urandom());
            do_frame(w, "R1 random");
        end

        // R9: reset mid-run clears everything
        do_frame(16'h0FFF, "R9 prefill");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_ctrl = '0; m_txf = '0; m_rxf = '0;
        check_outputs("R9 mid-run");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        do_frame(16'h8000, "R9 read after reset");

        finished = 1;
        finish_run();
    end

endmodule